// File: doc/BRIEF.md
# End-of-Text Bounded Cursor Transmit Extractor

This block sends text out of a recirculating character memory. The memory presents one character slot per strobe and marks the slot that holds the cursor. A transmit request starts a scan over one full memory pass, which looks for an end-of-text code. If the scan finds the code, the block turns on its transmit enable. If the scan does not find it, the block goes back to idle and sends nothing.

While enabled, the block takes the character under the cursor each time the cursor slot goes past. It pulses a cursor-step output in the same cycle, so the memory moves the cursor one position to the right. Because of that step, the next slot in the same pass is the new cursor slot. Up to two characters can be taken in a row, limited by the free space in a small holding buffer. When the cursor reaches an end-of-text code, that code is not taken. The block drops its enable and pulses done.

Queued characters leave most significant bit first on a valid/ready serial stream. Back-pressure rules: a bit moves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the bit and its last flag hold still. A full holding buffer makes the block let the cursor slot pass untaken and unstepped. The same character is then taken on a later pass.

Top module: `etx_xmit_extractor`

## Requirements
- R1: After reset, `xmit_on`, `xmit_done`, `tx_valid` and `cur_step` are all low, even while a cursor slot is presented.
- R2: A request seen while idle starts a scan of the next DEPTH strobed slots. The first slot in that scan holding the end-of-text code 7'h03 makes `xmit_on` rise in the following cycle.
- R3: If none of those DEPTH slots holds 7'h03, the block returns to idle. `xmit_on`, `tx_valid` and `cur_step` then stay low.
- R4: While `xmit_on` is high, a strobed cursor slot whose character is not 7'h03 and that finds the holding buffer not full raises `cur_step` in that same cycle and queues the character.
- R5: While `xmit_on` is high, a strobed cursor slot holding 7'h03 is not queued and raises no `cur_step`. In the next cycle `xmit_on` is low and `xmit_done` is high, for that one cycle only.
- R6: Each queued character leaves as CW serial bits, most significant bit first. `tx_last` marks the CW-th bit, which is the least significant bit. While `tx_valid` is high and `tx_ready` is low, `tx_bit` and `tx_last` stay stable.
- R7: The holding buffer keeps HOLD characters (default 2). A cursor slot that arrives while it is full is neither taken nor stepped. Over a whole transfer, the characters from the start cursor up to the end-of-text code come out once each, in memory order, and the cursor finishes on the end-of-text slot.
- R8: `cur_step` is high only in a cycle with a strobed cursor slot while `xmit_on` is high.
- R9: A request that arrives while scanning or transmitting has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xmit_req | input | 1 | Transmit request pulse |
| slot_stb | input | 1 | A memory slot is presented this cycle |
| slot_char | input | CW | Character code of the presented slot |
| slot_cur | input | 1 | The presented slot holds the cursor |
| cur_step | output | 1 | Move the cursor right by one (same cycle as the slot) |
| tx_valid | output | 1 | A serial bit is offered |
| tx_ready | input | 1 | Downstream buffer accepts the bit |
| tx_bit | output | 1 | Serial data bit, most significant bit first |
| tx_last | output | 1 | Final bit of the current character |
| xmit_on | output | 1 | Transmit sequence enabled |
| xmit_done | output | 1 | One-cycle pulse when the end-of-text code is reached |

## Verification
Several properties are checked on every cycle:
- the enable rises only after a strobed end-of-text slot;
- the done pulse lasts one cycle and coincides with the enable falling;
- the holding buffer is never pushed when full or popped when empty;
- a step is always followed by offered data;
- a stalled bit holds still.

Other behaviour only the scenarios can show:
- the exact character order and count;
- the final cursor position;
- recovery after pauses caused by a full buffer;
- the silent outcome of a scan that finds nothing.

The bench shows these by sweeping every start position, every end-of-text position and three back-pressure patterns.

// File: rtl/txe_pkg.sv
package txe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RUN  = 2'd2
  } txe_state_e;
endpackage

// File: rtl/txe_ctrl.sv
module txe_ctrl
  import txe_pkg::*;
#(
  parameter int CW    = 7,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xmit_req,
  input  logic          slot_stb,
  input  logic [CW-1:0] slot_char,
  input  logic          slot_cur,
  input  logic          hold_full,
  output logic          push,
  output logic          cur_step,
  output logic          xmit_on,
  output logic          xmit_done
);
  localparam int CNTW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] ETX = CW'(3);
  localparam logic [CNTW-1:0] CNT_END = CNTW'(DEPTH - 1);

  txe_state_e state_q;
  logic [CNTW-1:0] cnt_q;
  logic is_etx, run, term;

  always_comb begin
    is_etx   = (slot_char == ETX);
    run      = (state_q == ST_RUN);
    term     = run && slot_stb && slot_cur && is_etx;
    push     = run && slot_stb && slot_cur && !is_etx && !hold_full;
    cur_step = push;
    xmit_on  = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      xmit_done <= 1'b0;
    end else begin
      xmit_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (xmit_req) begin
          state_q <= ST_SCAN;
          cnt_q   <= '0;
        end
        ST_SCAN: if (slot_stb) begin
          if (is_etx)                state_q <= ST_RUN;
          else if (cnt_q == CNT_END) state_q <= ST_IDLE;
          else                       cnt_q   <= cnt_q + 1'b1;
        end
        ST_RUN: if (term) begin
          state_q   <= ST_IDLE;
          xmit_done <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  enable_after_etx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_on) |-> $past(slot_stb && is_etx));
  // R5
  done_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_done |-> (!xmit_on && $past(xmit_on)));
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_done |=> !xmit_done);
endmodule

// File: rtl/txe_hold_fifo.sv
module txe_hold_fifo #(
  parameter int CW   = 7,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] din,
  input  logic          pop,
  output logic [CW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int NW = $clog2(HOLD + 1);
  localparam logic [PW-1:0] PTR_END = PW'(HOLD - 1);

  logic [CW-1:0] mem_q [HOLD];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] num_q;

  assign head  = mem_q[rd_q];
  assign empty = (num_q == '0);
  assign full  = (num_q == NW'(HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      num_q <= '0;
      for (int i = 0; i < HOLD; i++) mem_q[i] <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q <= (wr_q == PTR_END) ? '0 : wr_q + 1'b1;
      end
      if (pop) rd_q <= (rd_q == PTR_END) ? '0 : rd_q + 1'b1;
      num_q <= num_q + NW'(push) - NW'(pop);
    end
  end

  // R7
  hold_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R7
  hold_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4
  step_gives_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !empty);
endmodule

// File: rtl/txe_serializer.sv
module txe_serializer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] head,
  input  logic          empty,
  output logic          pop,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_bit,
  output logic          tx_last
);
  localparam int IW = (CW > 1) ? $clog2(CW) : 1;
  localparam logic [IW-1:0] IDX_END = IW'(CW - 1);

  logic [IW-1:0] idx_q;
  logic [CW-1:0] sh;
  logic fire;

  always_comb begin
    sh       = head << idx_q;
    tx_valid = !empty;
    tx_bit   = sh[CW-1];
    tx_last  = (idx_q == IDX_END);
    fire     = tx_valid && tx_ready;
    pop      = fire && tx_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (fire) idx_q <= tx_last ? '0 : idx_q + 1'b1;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit) && $stable(tx_last)));
endmodule

// File: rtl/etx_xmit_extractor.sv
module etx_xmit_extractor #(
  parameter int CW    = 7,
  parameter int DEPTH = 16,
  parameter int HOLD  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xmit_req,
  input  logic          slot_stb,
  input  logic [CW-1:0] slot_char,
  input  logic          slot_cur,
  output logic          cur_step,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_bit,
  output logic          tx_last,
  output logic          xmit_on,
  output logic          xmit_done
);
  logic          push, pop, empty, full;
  logic [CW-1:0] head;

  txe_ctrl #(.CW(CW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .xmit_req(xmit_req), .slot_stb(slot_stb),
    .slot_char(slot_char), .slot_cur(slot_cur), .hold_full(full),
    .push(push), .cur_step(cur_step), .xmit_on(xmit_on), .xmit_done(xmit_done)
  );

  txe_hold_fifo #(.CW(CW), .HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(push), .din(slot_char), .pop(pop),
    .head(head), .empty(empty), .full(full)
  );

  txe_serializer #(.CW(CW)) u_ser (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(empty), .pop(pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit), .tx_last(tx_last)
  );

  // R8
  step_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_step |-> (slot_stb && slot_cur && xmit_on));
endmodule

// File: tb/etx_xmit_extractor_tb.sv
module etx_xmit_extractor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 7;
  localparam int D  = 8;
  localparam int HOLD = 2;
  localparam logic [CW-1:0] ETX = 7'h03;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xmit_req = 1'b0, slot_stb = 1'b0, slot_cur = 1'b0, tx_ready = 1'b0;
  logic [CW-1:0] slot_char = '0;
  logic cur_step, tx_valid, tx_bit, tx_last, xmit_on, xmit_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  etx_xmit_extractor #(.CW(CW), .DEPTH(D), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .xmit_req(xmit_req), .slot_stb(slot_stb),
    .slot_char(slot_char), .slot_cur(slot_cur), .cur_step(cur_step),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit), .tx_last(tx_last),
    .xmit_on(xmit_on), .xmit_done(xmit_done)
  );

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] mem [D];
  logic [CW-1:0] rx [64];
  logic [CW-1:0] shreg;
  int pos, idx, cyc, mode, nrx, nbits, nsteps, ndone, bad_step, bad_last;
  int on_cyc, etx_cyc;
  bit on_seen, any_valid, etx_found, scan_armed, req_next, req_phase;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ready_for(input int m, input int c);
    case (m)
      0: return 1'b1;
      1: return (c % 3) == 0;
      default: return (c % 20) >= 14;
    endcase
  endfunction

  task automatic clear_obs();
    nrx = 0; nbits = 0; nsteps = 0; ndone = 0; bad_step = 0; bad_last = 0;
    on_seen = 0; any_valid = 0; etx_found = 0; scan_armed = 0; shreg = '0;
    on_cyc = -1; etx_cyc = -1;
  endtask

  task automatic cycle();
    @(negedge clk);
    slot_stb  = 1'b1;
    slot_char = mem[idx];
    slot_cur  = (idx == pos);
    xmit_req  = req_next;
    req_phase = req_next;
    req_next  = 1'b0;
    tx_ready  = ready_for(mode, cyc);
    #1;
    if (cur_step) begin
      if (!slot_cur || !xmit_on) bad_step++;
      nsteps++;
    end
    if (tx_valid) any_valid = 1;
    if (tx_valid && tx_ready) begin
      shreg = {shreg[CW-2:0], tx_bit};
      nbits++;
      if (tx_last) begin
        if (nbits != CW) bad_last++;
        if (nrx < 64) rx[nrx] = shreg;
        nrx++;
        nbits = 0;
      end
    end
    if (xmit_done) ndone++;
    if (xmit_on && !on_seen) begin on_seen = 1; on_cyc = cyc; end
    if (scan_armed && !etx_found && slot_char == ETX) begin
      etx_found = 1; etx_cyc = cyc;
    end
    if (req_phase) scan_armed = 1;
    if (cur_step) pos = (pos + 1) % D;
    idx = (idx + 1) % D;
    cyc++;
  endtask

  task automatic do_run(input int start, input int k, input int m);
    int n, guard;
    bit mism, req_again;
    for (int i = 0; i < D; i++) mem[i] = (i == k) ? ETX : CW'(8'h41 + i);
    pos = start; mode = m;
    clear_obs();
    req_next = 1'b1;
    req_again = 0;
    guard = 0;
    do begin
      cycle();
      guard++;
      // R9: second request during transmission must be ignored
      if (m == 1 && xmit_on && !req_again && ndone == 0) begin
        req_next = 1'b1; req_again = 1;
      end
    end while (!(ndone > 0 && !tx_valid) && guard < 3000);
    repeat (2) cycle();
    n = (k - start + D) % D;
    chk(guard < 3000, "R7 transfer completes", guard, 3000);
    chk(nrx == n, "R7 character count", nrx, n);
    mism = 0;
    for (int j = 0; j < n && j < nrx; j++)
      if (rx[j] != CW'(8'h41 + ((start + j) % D))) mism = 1;
    chk(!mism, "R6 msb-first order and content", mism, 0);
    chk(bad_last == 0, "R6 tx_last on bit CW", bad_last, 0);
    chk(nsteps == n, "R4 cursor steps", nsteps, n);
    chk(pos == k, "R7 cursor ends on end-of-text", pos, k);
    chk(ndone == 1, (m == 1) ? "R9 single done with extra request" : "R5 single done pulse", ndone, 1);
    chk(!xmit_on, "R5 enable dropped", xmit_on, 0);
    chk(on_cyc == etx_cyc + 1, "R2 enable timing", on_cyc, etx_cyc + 1);
    chk(bad_step == 0, "R8 step only on enabled cursor slot", bad_step, 0);
  endtask

  initial begin
    for (int i = 0; i < D; i++) mem[i] = CW'(8'h41 + i);
    pos = 0; idx = 0; cyc = 0; mode = 0; req_next = 0;
    clear_obs();
    slot_stb = 1'b1; slot_cur = 1'b1; slot_char = 7'h41; tx_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!xmit_on,   "R1 xmit_on reset",   xmit_on, 0);
    chk(!xmit_done, "R1 xmit_done reset", xmit_done, 0);
    chk(!tx_valid,  "R1 tx_valid reset",  tx_valid, 0);
    chk(!cur_step,  "R1 cur_step reset",  cur_step, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: no end-of-text anywhere
    clear_obs();
    req_next = 1'b1;
    repeat (3 * D) cycle();
    chk(!on_seen,   "R3 no enable without end-of-text", on_seen, 0);
    chk(!any_valid, "R3 no data without end-of-text", any_valid, 0);
    chk(nsteps == 0, "R3 no steps without end-of-text", nsteps, 0);

    for (int m = 0; m < 3; m++)
      for (int s = 0; s < D; s++)
        for (int k = 0; k < D; k++)
          do_run(s, k, m);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule